// File: doc/BRIEF.md
# Interrupt latency measurement unit

This block times the interval between two single-bit events, in clock cycles. A rising edge on the start input marks an interrupt being raised, and a rising edge on the stop input marks that interrupt being serviced. Each finished interval is a 16-bit sample. The block appends every sample to an on-chip log memory of `LOG_DEPTH` words. Alongside the log it keeps the most recent sample, the minimum, the maximum, a sample count, and a sticky flag that is raised when a sample exceeds a programmable limit.

A measurement harness attaches the two event inputs to the signals under observation and holds the enable high for as long as sampling should run. It reads results back in two ways. A registered read port returns log entries. A second registered read port returns the statistics by selector code. The same statistics are also driven directly on output pins.

Top module: `irq_lat_meter`

## Requirements
- R1: Each event input is registered and only its rising edge counts. An input held high for many cycles produces one event, and a start edge seen while a measurement is pending restarts it only on a fresh rising edge.
- R2: If the start input is first sampled high at clock edge k and the stop input is first sampled high at edge k+L, the recorded sample is L.
- R3: While the enable input is low, start edges are ignored. Dropping the enable abandons any pending measurement, so a later stop edge records nothing.
- R4: A stop edge with no pending measurement is ignored. The log, the count and all statistics stay unchanged.
- R5: A start edge that arrives while a measurement is pending discards it and restarts timing from the new edge.
- R6: The interval counter saturates at 0xFFFF. A longer interval records 0xFFFF.
- R7: Samples are written to consecutive log addresses starting at 0, and the address wraps from `LOG_DEPTH`-1 back to 0. The log read port returns the entry at `log_raddr_i` one clock later.
- R8: `last_o` holds the newest sample, `min_o` the smallest, `max_o` the largest, and `count_o` the number of samples, modulo 2^16. After reset they read 0, 0xFFFF, 0 and 0 respectively.
- R9: `alarm_o` sets when a sample is strictly greater than `limit_i`. It stays set until `alarm_clr_i` is high at a clock edge. If a setting sample coincides with the clear, the set wins.
- R10: The statistics read port returns, one clock after the selector is applied: code 0 the last sample, 1 the maximum, 2 the minimum, 3 the count, and 4 the alarm in bit 0. Any other code returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Start event (interrupt raised) |
| ack_i | input | 1 | Stop event (interrupt serviced) |
| en_i | input | 1 | Measurement enable |
| alarm_clr_i | input | 1 | Clears the sticky alarm |
| limit_i | input | 16 | Alarm limit |
| last_o | output | 16 | Newest sample |
| max_o | output | 16 | Largest sample |
| min_o | output | 16 | Smallest sample |
| count_o | output | 16 | Number of samples |
| alarm_o | output | 1 | Sticky over-limit flag |
| log_raddr_i | input | 9 | Log read address |
| log_rdata_o | output | 16 | Log read data, one cycle after the address |
| stat_sel_i | input | 3 | Statistics selector |
| stat_rdata_o | output | 16 | Statistics read data, one cycle after the selector |

## Verification
Two situations are hard to reach from the ports. The first is the same-edge race between a setting sample and an alarm clear. The stimulus raises the clear exactly one cycle after the stop input has been sampled, which is the edge where the sample commits. The second is counter saturation, which needs an interval longer than 65535 cycles. One measurement holds the stop back for 70000 cycles. Log wraparound is covered by filling the whole log with more than `LOG_DEPTH` samples of varying length and then reading back every entry.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [2:0] {
    SEL_LAST  = 3'd0,
    SEL_MAX   = 3'd1,
    SEL_MIN   = 3'd2,
    SEL_COUNT = 3'd3,
    SEL_ALARM = 3'd4
  } stat_sel_e;
endpackage

// File: rtl/lat_edge_det.sv
module lat_edge_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s_q, s_qq;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q  <= 1'b0;
        s_qq <= 1'b0;
      end else begin
        s_q  <= sig_i[g];
        s_qq <= s_q;
      end
    end
    assign rise_o[g] = s_q & ~s_qq;

    // R1
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/lat_timer.sv
module lat_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         start_i,
  input  logic         stop_i,
  output logic         done_o,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] CntMax = {W{1'b1}};
  localparam logic [W-1:0] CntOne = W'(1);

  logic         pend_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      pend_q <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b1;
      cnt_q  <= CntOne;
    end else if (pend_q) begin
      if (stop_i)               pend_q <= 1'b0;
      else if (cnt_q != CntMax) cnt_q  <= cnt_q + CntOne;
    end
  end

  assign done_o  = en_i & pend_q & stop_i;
  assign value_o = cnt_q;

  // R6
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax && !(en_i && start_i)) |=> cnt_q == CntMax);
  // R4
  orphan_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !pend_q && !start_i) |=> !pend_q);
  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i) |=> (pend_q && cnt_q == CntOne));
  // R3
  disable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pend_q);
endmodule

// File: rtl/lat_log_ram.sv
module lat_log_ram #(
  parameter int DEPTH = 512,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam logic [AW-1:0] LastAddr = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wptr_q <= '0;
    else if (we_i) wptr_q <= (wptr_q == LastAddr) ? '0 : wptr_q + AW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wptr_q] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

  // R7
  wptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> wptr_q == (($past(wptr_q) == LastAddr) ? '0 : $past(wptr_q) + AW'(1)));
  // R7
  wptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(wptr_q));
endmodule

// File: rtl/lat_stats.sv
module lat_stats
  import lat_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] limit_i,
  input  logic         clr_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] last_o,
  output logic [W-1:0] max_o,
  output logic [W-1:0] min_o,
  output logic [W-1:0] count_o,
  output logic         alarm_o,
  output logic [W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_o  <= '0;
      max_o   <= '0;
      min_o   <= '1;
      count_o <= '0;
    end else if (done_i) begin
      last_o  <= value_i;
      count_o <= count_o + W'(1);
      if (value_i > max_o) max_o <= value_i;
      if (value_i < min_o) min_o <= value_i;
    end
  end

  // set takes priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          alarm_o <= 1'b0;
    else if (done_i && value_i > limit_i) alarm_o <= 1'b1;
    else if (clr_i)                       alarm_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else begin
      case (stat_sel_e'(sel_i))
        SEL_LAST:  rdata_o <= last_o;
        SEL_MAX:   rdata_o <= max_o;
        SEL_MIN:   rdata_o <= min_o;
        SEL_COUNT: rdata_o <= count_o;
        SEL_ALARM: rdata_o <= W'(alarm_o);
        default:   rdata_o <= '0;
      endcase
    end
  end

  // R9
  alarm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && value_i > limit_i) |=> alarm_o);
  // R9
  alarm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !clr_i) |=> alarm_o);
  // R8
  last_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> last_o == $past(value_i));
  // R8
  min_max_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |-> min_o <= max_o);
  // R10
  sel_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |=> rdata_o == $past(last_o));
endmodule

// File: rtl/irq_lat_meter.sv
module irq_lat_meter #(
  parameter int LOG_DEPTH = 512,
  parameter int DATA_W    = 16,
  localparam int AW       = $clog2(LOG_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              ack_i,
  input  logic              en_i,
  input  logic              alarm_clr_i,
  input  logic [DATA_W-1:0] limit_i,
  output logic [DATA_W-1:0] last_o,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] count_o,
  output logic              alarm_o,
  input  logic [AW-1:0]     log_raddr_i,
  output logic [DATA_W-1:0] log_rdata_o,
  input  logic [2:0]        stat_sel_i,
  output logic [DATA_W-1:0] stat_rdata_o
);
  logic [1:0]        rise;
  logic              done;
  logic [DATA_W-1:0] value;

  lat_edge_det #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({ack_i, irq_i}),
    .rise_o (rise)
  );

  lat_timer #(.W(DATA_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (rise[0]),
    .stop_i  (rise[1]),
    .done_o  (done),
    .value_o (value)
  );

  lat_log_ram #(.DEPTH(LOG_DEPTH), .W(DATA_W)) u_log (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done),
    .wdata_i (value),
    .raddr_i (log_raddr_i),
    .rdata_o (log_rdata_o)
  );

  lat_stats #(.W(DATA_W)) u_stats (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .value_i (value),
    .limit_i (limit_i),
    .clr_i   (alarm_clr_i),
    .sel_i   (stat_sel_i),
    .last_o  (last_o),
    .max_o   (max_o),
    .min_o   (min_o),
    .count_o (count_o),
    .alarm_o (alarm_o),
    .rdata_o (stat_rdata_o)
  );

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(count_o));
endmodule

// File: tb/tb_irq_lat_meter.sv
module tb_irq_lat_meter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic irq = 1'b0, ack = 1'b0, en = 1'b1, clr = 1'b0;
  logic [15:0] limit = 16'hFFFF;
  logic [15:0] last_o, max_o, min_o, count_o, log_rdata, stat_rdata;
  logic alarm_o;
  logic [8:0] raddr = '0;
  logic [2:0] sel = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  int e_last = 0, e_max = 0, e_min = 16'hFFFF, e_count = 0, e_wp = 0;
  bit e_alarm = 0;
  int e_log [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_lat_meter dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .ack_i(ack), .en_i(en),
    .alarm_clr_i(clr), .limit_i(limit), .last_o(last_o), .max_o(max_o),
    .min_o(min_o), .count_o(count_o), .alarm_o(alarm_o),
    .log_raddr_i(raddr), .log_rdata_o(log_rdata),
    .stat_sel_i(sel), .stat_rdata_o(stat_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_sample(input int l, input bit c);
    int v = (l > 65535) ? 65535 : l;
    e_last = v;
    if (v > e_max) e_max = v;
    if (v < e_min) e_min = v;
    e_count = (e_count + 1) % 65536;
    e_log[e_wp] = v;
    e_wp = (e_wp + 1) % DEPTH;
    if (v > int'(limit)) e_alarm = 1;
    else if (c) e_alarm = 0;
  endtask

  // start sampled at edge k, stop at edge k+l
  task automatic measure(input int l, input bit clr_at_done);
    @(negedge clk) irq = 1;
    @(negedge clk) irq = 0;
    repeat (l - 1) @(negedge clk);
    ack = 1;
    @(negedge clk) ack = 0; clr = clr_at_done;
    @(negedge clk) clr = 0;
    repeat (2) @(negedge clk);
    model_sample(l, clr_at_done);
  endtask

  task automatic check_stats(input string req);
    chk({req, " last"}, last_o, e_last);
    chk({req, " max"}, max_o, e_max);
    chk({req, " min"}, min_o, e_min);
    chk({req, " count"}, count_o, e_count);
    chk({req, " alarm"}, alarm_o, e_alarm);
  endtask

  task automatic rd_log(input int a, input string req);
    @(negedge clk) raddr = 9'(a);
    @(negedge clk) chk(req, log_rdata, e_log[a]);
  endtask

  task automatic rd_stat(input int s, input int exp, input string req);
    @(negedge clk) sel = 3'(s);
    @(negedge clk) chk(req, stat_rdata, exp);
  endtask

  task automatic t_reset;
    check_stats("R8 reset");
  endtask

  task automatic t_basic;
    measure(10, 0); chk("R2 L=10", last_o, 10);
    measure(3, 0);  chk("R2 L=3", last_o, 3);
    measure(25, 0); chk("R2 L=25", last_o, 25);
    measure(1, 0);  chk("R2 L=1", last_o, 1);
    check_stats("R8 basic");
    for (int i = 0; i < 4; i++) rd_log(i, "R7 log readback");
  endtask

  task automatic t_held;
    @(negedge clk) irq = 1;
    repeat (5) @(negedge clk);
    irq = 0;
    repeat (3) @(negedge clk);
    ack = 1;
    repeat (6) @(negedge clk);
    ack = 0;
    repeat (3) @(negedge clk);
    model_sample(8, 0);
    chk("R1 held inputs one sample", count_o, e_count);
    chk("R1 held value", last_o, 8);
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
    repeat (4) @(negedge clk);
    check_stats("R4 orphan stop ignored");
  endtask

  task automatic t_enable;
    @(negedge clk) en = 0;
    @(negedge clk) irq = 1;
    @(negedge clk) irq = 0;
    repeat (3) @(negedge clk);
    ack = 1;
    @(negedge clk) ack = 0;
    repeat (3) @(negedge clk);
    en = 1;
    check_stats("R3 disabled start ignored");
    @(negedge clk) irq = 1;
    @(negedge clk) irq = 0;
    repeat (2) @(negedge clk);
    en = 0;
    repeat (2) @(negedge clk);
    en = 1;
    repeat (3) @(negedge clk);
    ack = 1;
    @(negedge clk) ack = 0;
    repeat (4) @(negedge clk);
    check_stats("R3 pending abandoned");
  endtask

  task automatic t_restart;
    @(negedge clk) irq = 1;
    @(negedge clk) irq = 0;
    repeat (5) @(negedge clk);
    irq = 1;
    @(negedge clk) irq = 0;
    repeat (3) @(negedge clk);
    ack = 1;
    @(negedge clk) ack = 0;
    repeat (4) @(negedge clk);
    model_sample(4, 0);
    chk("R5 restart value", last_o, 4);
    chk("R5 restart one sample", count_o, e_count);
  endtask

  task automatic t_alarm;
    @(negedge clk) limit = 16'd20;
    measure(20, 0); chk("R9 equal to limit no alarm", alarm_o, 0);
    measure(21, 0); chk("R9 above limit sets", alarm_o, 1);
    measure(5, 0);  chk("R9 sticky", alarm_o, 1);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    e_alarm = 0;
    chk("R9 clear", alarm_o, 0);
    measure(30, 1); chk("R9 set wins over clear", alarm_o, 1);
    measure(6, 1);  chk("R9 clear with low sample", alarm_o, 0);
    @(negedge clk) limit = 16'hFFFF;
    check_stats("R9 after alarm test");
  endtask

  task automatic t_stat_port;
    rd_stat(0, e_last, "R10 sel last");
    rd_stat(1, e_max, "R10 sel max");
    rd_stat(2, e_min, "R10 sel min");
    rd_stat(3, e_count, "R10 sel count");
    rd_stat(4, e_alarm, "R10 sel alarm");
    rd_stat(6, 0, "R10 sel unused");
  endtask

  task automatic t_sat;
    measure(70000, 0);
    chk("R6 saturated sample", last_o, 16'hFFFF);
    chk("R6 max saturated", max_o, 16'hFFFF);
    chk("R9 max limit no alarm", alarm_o, 0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < DEPTH + 3; i++) measure(1 + (i % 7), 0);
    check_stats("R8 after wrap");
    for (int a = 0; a < DEPTH; a++) rd_log(a, "R7 wrapped log");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_held;
    t_enable;
    t_restart;
    t_alarm;
    t_stat_port;
    t_sat;
    t_wrap;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule